// File: doc/BRIEF.md
# Clock-Analog and Power Register Window Map

This block is the register container of a clock-analog and power-management unit. It occupies a 64 KiB slice of a 32-bit register bus. Three windows are decoded inside it: an array of PLL and analog control words, an array of power-management words, and one read-only identification word. Software reads configuration values back and changes them in place. The registers only hold values. Nothing in the block models a real PLL, a frequency or a power sequence.

Each register takes up a 16-byte group of addresses. The word offset inside the group selects how a write acts on the stored value. Software can therefore set, clear or flip single bits without a read-modify-write. Reset loads the PLL array with fixed configuration words and forces every PLL lock flag to one. Software that polls for lock therefore proceeds at once.

The bus has no back-pressure and no handshake. An access is the single cycle in which `we_i` or `re_i` is high. It always completes in that cycle. Read data and the error pulse appear on the following cycle.

Top module: `pllpmu_regmap`

## Requirements
- R1: The PLL window starts at byte offset 0x60 and spans ANA_WORDS*4 bytes. The power window starts at 0x200 and spans PMU_WORDS*4 bytes. Inside a window, the register index is (offset from window base) >> 4, so registers sit at a 16-byte pitch.
- R2: On a write, offset bits [3:2] within the window select the action. 0 replaces the register with the data. 1 ORs the data in. 2 clears the bits that are one in the data. 3 XORs the data in.
- R3: A read of any of the four addresses of a register group returns the stored word on `rdata_o` in the cycle after `re_i`. `rdata_o` holds its value while `re_i` is low.
- R4: Where windows overlap, the identification word at 0x800 has the highest priority, then the power window, then the PLL window.
- R5: A read at 0x800 returns 0x00720010. A write to 0x800 changes no register and raises `err_o` in the next cycle.
- R6: After reset, every power register is zero and the PLL registers hold the following values, by index. 0=0x80002042, 1=0x8060302c, 3=0x06aaac4d, 4=0x100003ec, 5=0x80002000, 6=0xd2605a56, 7=0xd2525216, 8=0x80001fc0, 9=0x8001301b, 11=0x05f5e100, 12=0x2964619c, 13=0x8008201b, 15=0x0000f699, 16=0x000f4240, 17=0x80000000. All other indices are zero. Bit 31 is the lock flag and is set only in the control words 0, 1, 5, 6, 7, 8, 9, 13 and 17. `rdata_o` and `err_o` are zero.
- R7: An access to an aligned address that falls in no window reads zero, stores nothing and raises `err_o` in the next cycle.
- R8: An access whose address bits [1:0] are not zero is handled like an access that falls in no window.
- R9: When `we_i` and `re_i` are high in the same cycle on one register, the read returns the value from before that write.
- R10: `err_o` is high for exactly one cycle after each flagged access cycle. It is low after every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (16) | Byte address inside the container |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, one access per cycle |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read result, valid the cycle after `re_i` |
| err_o | output | 1 | One-cycle pulse for an unmapped, misaligned or read-only write access |

## Verification
The hardest case to reach is the identification word taking priority over a window that covers it. With the default array sizes, no window reaches 0x800. The bench therefore builds the block with a 512-word power window, which spans 0x200 to 0x9FF. Writes to 0x800 must then leave power register 96 untouched, while the neighbouring alias addresses 0x804 to 0x80C still reach that register. The same build exercises the power window taking over the top of the PLL window. A behavioural model follows every cycle of directed and random traffic.

// File: rtl/regmap_pkg.sv
package regmap_pkg;

  localparam int REG_W    = 32;
  localparam int LOCK_BIT = 31;

  localparam int BANK_ZERO = 0;
  localparam int BANK_PLL  = 1;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_FLIP  = 2'd3
  } alias_op_t;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_ANA  = 2'd1,
    WIN_PMU  = 2'd2,
    WIN_ID   = 2'd3
  } win_t;

  // configuration words of the PLL array before lock flags are applied
  function automatic logic [REG_W-1:0] pll_base(input int idx);
    logic [REG_W-1:0] w;
    case (idx)
      0:       w = 32'h0000_2042;
      1:       w = 32'h0060_302c;
      3:       w = 32'h06aa_ac4d;
      4:       w = 32'h1000_03ec;
      5:       w = 32'h0000_2000;
      6:       w = 32'h5260_5a56;
      7:       w = 32'h5252_5216;
      8:       w = 32'h0000_1fc0;
      9:       w = 32'h0001_301b;
      11:      w = 32'h05f5_e100;
      12:      w = 32'h2964_619c;
      13:      w = 32'h0008_201b;
      15:      w = 32'h0000_f699;
      16:      w = 32'h000f_4240;
      default: w = '0;
    endcase
    return w;
  endfunction

  // control words (not spread, numerator or denominator) carry a lock flag
  function automatic logic pll_has_lock(input int idx);
    return (idx == 0) || (idx == 1) || (idx == 5) || (idx == 6) ||
           (idx == 7) || (idx == 8) || (idx == 9) || (idx == 13) ||
           (idx == 17);
  endfunction

  function automatic logic [REG_W-1:0] bank_reset_word(input int kind, input int idx);
    logic [REG_W-1:0] w;
    w = '0;
    if (kind == BANK_PLL) begin
      w = pll_base(idx);
      if (pll_has_lock(idx)) w[LOCK_BIT] = 1'b1;
    end
    return w;
  endfunction

endpackage

// File: rtl/regmap_decode.sv
module regmap_decode
  import regmap_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int ANA_BASE  = 'h60,
  parameter int ANA_WORDS = 128,
  parameter int PMU_BASE  = 'h200,
  parameter int PMU_WORDS = 128,
  parameter int ID_ADDR   = 'h800,
  parameter int ANA_IDX_W = 5,
  parameter int PMU_IDX_W = 5
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output win_t                 win_o,
  output alias_op_t            op_o,
  output logic [ANA_IDX_W-1:0] ana_idx_o,
  output logic [PMU_IDX_W-1:0] pmu_idx_o
);

  localparam logic [ADDR_W:0] ANA_LO = (ADDR_W+1)'(ANA_BASE);
  localparam logic [ADDR_W:0] ANA_HI = (ADDR_W+1)'(ANA_BASE + ANA_WORDS*4);
  localparam logic [ADDR_W:0] PMU_LO = (ADDR_W+1)'(PMU_BASE);
  localparam logic [ADDR_W:0] PMU_HI = (ADDR_W+1)'(PMU_BASE + PMU_WORDS*4);
  localparam logic [ADDR_W:0] ID_A   = (ADDR_W+1)'(ID_ADDR);

  logic [ADDR_W:0] a_ext, ana_off, pmu_off;
  logic            aligned, in_ana, in_pmu, is_id;
  logic            unused_off_bits;

  assign a_ext   = {1'b0, addr_i};
  assign ana_off = a_ext - ANA_LO;
  assign pmu_off = a_ext - PMU_LO;
  assign aligned = (addr_i[1:0] == 2'b00);
  assign in_ana  = (a_ext >= ANA_LO) && (a_ext < ANA_HI);
  assign in_pmu  = (a_ext >= PMU_LO) && (a_ext < PMU_HI);
  assign is_id   = (a_ext == ID_A);

  assign ana_idx_o = ana_off[ANA_IDX_W+3:4];
  assign pmu_idx_o = pmu_off[PMU_IDX_W+3:4];

  // priority: identification word, then power window, then PLL window
  always_comb begin
    win_o = WIN_NONE;
    op_o  = OP_WRITE;
    if (aligned) begin
      if (is_id) begin
        win_o = WIN_ID;
      end else if (in_pmu) begin
        win_o = WIN_PMU;
        op_o  = alias_op_t'(pmu_off[3:2]);
      end else if (in_ana) begin
        win_o = WIN_ANA;
        op_o  = alias_op_t'(ana_off[3:2]);
      end
    end
  end

  assign unused_off_bits = ^{ana_off[ADDR_W:ANA_IDX_W+4], ana_off[1:0],
                             pmu_off[ADDR_W:PMU_IDX_W+4], pmu_off[1:0]};

endmodule

// File: rtl/regmap_bank.sv
module regmap_bank
  import regmap_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int KIND  = BANK_ZERO,
  parameter int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  alias_op_t        wr_op,
  input  logic [REG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [REG_W-1:0] rd_data
);

  logic [REG_W-1:0] regs_q [NREGS];
  logic [REG_W-1:0] cur, nxt;

  assign cur = regs_q[wr_idx];

  always_comb begin
    case (wr_op)
      OP_SET:   nxt = cur | wr_data;
      OP_CLEAR: nxt = cur & ~wr_data;
      OP_FLIP:  nxt = cur ^ wr_data;
      default:  nxt = wr_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= bank_reset_word(KIND, i);
    end else if (wr_en) begin
      regs_q[wr_idx] <= nxt;
    end
  end

  assign rd_data = regs_q[rd_idx];

  // R2
  replace_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == OP_WRITE) |=> (regs_q[$past(wr_idx)] == $past(wr_data)));

  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == OP_SET) |=> ((regs_q[$past(wr_idx)] & $past(wr_data)) == $past(wr_data)));

  // R2
  clear_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == OP_CLEAR) |=> ((regs_q[$past(wr_idx)] & $past(wr_data)) == '0));

  // R2
  flip_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == OP_FLIP) |=> (regs_q[$past(wr_idx)] == ($past(cur) ^ $past(wr_data))));

endmodule

// File: rtl/pllpmu_regmap.sv
module pllpmu_regmap
  import regmap_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          ANA_BASE  = 'h60,
  parameter int          ANA_WORDS = 128,
  parameter int          PMU_BASE  = 'h200,
  parameter int          PMU_WORDS = 128,
  parameter int          ID_ADDR   = 'h800,
  parameter logic [31:0] ID_VALUE  = 32'h0072_0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [31:0]       rdata_o,
  output logic              err_o
);

  localparam int ANA_REGS  = ANA_WORDS / 4;
  localparam int PMU_REGS  = PMU_WORDS / 4;
  localparam int ANA_IDX_W = $clog2(ANA_REGS);
  localparam int PMU_IDX_W = $clog2(PMU_REGS);

  win_t                 win;
  alias_op_t            op;
  logic [ANA_IDX_W-1:0] ana_idx;
  logic [PMU_IDX_W-1:0] pmu_idx;
  logic [REG_W-1:0]     ana_rd, pmu_rd;
  logic                 ana_we, pmu_we, flag;
  logic [REG_W-1:0]     rdata_q;
  logic                 err_q;

  regmap_decode #(
    .ADDR_W(ADDR_W), .ANA_BASE(ANA_BASE), .ANA_WORDS(ANA_WORDS),
    .PMU_BASE(PMU_BASE), .PMU_WORDS(PMU_WORDS), .ID_ADDR(ID_ADDR),
    .ANA_IDX_W(ANA_IDX_W), .PMU_IDX_W(PMU_IDX_W)
  ) u_decode (
    .addr_i(addr_i), .win_o(win), .op_o(op),
    .ana_idx_o(ana_idx), .pmu_idx_o(pmu_idx)
  );

  assign ana_we = we_i && (win == WIN_ANA);
  assign pmu_we = we_i && (win == WIN_PMU);

  regmap_bank #(.NREGS(ANA_REGS), .KIND(BANK_PLL)) u_ana_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(ana_we), .wr_idx(ana_idx), .wr_op(op),
    .wr_data(wdata_i), .rd_idx(ana_idx), .rd_data(ana_rd)
  );

  regmap_bank #(.NREGS(PMU_REGS), .KIND(BANK_ZERO)) u_pmu_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(pmu_we), .wr_idx(pmu_idx), .wr_op(op),
    .wr_data(wdata_i), .rd_idx(pmu_idx), .rd_data(pmu_rd)
  );

  assign flag = ((we_i || re_i) && (win == WIN_NONE)) || (we_i && (win == WIN_ID));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= flag;
      if (re_i) begin
        case (win)
          WIN_ANA: rdata_q <= ana_rd;
          WIN_PMU: rdata_q <= pmu_rd;
          WIN_ID:  rdata_q <= ID_VALUE;
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  // R4
  bank_we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ana_we, pmu_we}));

  // R5
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (re_i && addr_i == ADDR_W'(ID_ADDR)) |=> (rdata_o == ID_VALUE));

  // R7
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (re_i && win == WIN_NONE) |=> (rdata_o == '0));

  // R8
  misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((we_i || re_i) && addr_i[1:0] != 2'b00) |=> err_o);

  // R10
  quiet_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i && !re_i) |=> !err_o);

endmodule

// File: tb/pllpmu_regmap_bench.sv
module pllpmu_regmap_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ANA_B  = 'h60;
  localparam int ANA_W  = 128;
  localparam int PMU_B  = 'h200;
  localparam int PMU_W  = 512;
  localparam int ID_A   = 'h800;
  localparam logic [31:0] ID_V = 32'h0072_0010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] rdata;
  logic        err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_ana [ANA_W/4];
  logic [31:0] m_pmu [PMU_W/4];
  logic [31:0] exp_rdata;
  logic        exp_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  pllpmu_regmap #(.PMU_WORDS(PMU_W)) u_pllpmu_regmap (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .err_o(err)
  );

  function automatic logic [31:0] ana_init(input int i);
    case (i)
      0:  return 32'h8000_2042;
      1:  return 32'h8060_302c;
      3:  return 32'h06aa_ac4d;
      4:  return 32'h1000_03ec;
      5:  return 32'h8000_2000;
      6:  return 32'hd260_5a56;
      7:  return 32'hd252_5216;
      8:  return 32'h8000_1fc0;
      9:  return 32'h8001_301b;
      11: return 32'h05f5_e100;
      12: return 32'h2964_619c;
      13: return 32'h8008_201b;
      15: return 32'h0000_f699;
      16: return 32'h000f_4240;
      17: return 32'h8000_0000;
      default: return 32'h0;
    endcase
  endfunction

  // kind: 0 none, 1 PLL, 2 power, 3 identification
  function automatic void mdec(input logic [15:0] a, output int kind,
                               output int idx, output int op);
    int ia;
    ia = int'(a);
    kind = 0; idx = 0; op = 0;
    if (ia % 4 != 0) return;
    if (ia == ID_A) kind = 3;
    else if (ia >= PMU_B && ia < PMU_B + PMU_W*4) begin
      kind = 2; idx = (ia - PMU_B) / 16; op = ((ia - PMU_B) / 4) % 4;
    end else if (ia >= ANA_B && ia < ANA_B + ANA_W*4) begin
      kind = 1; idx = (ia - ANA_B) / 16; op = ((ia - ANA_B) / 4) % 4;
    end
  endfunction

  function automatic logic [31:0] apply(input logic [31:0] v, input logic [31:0] d, input int op);
    case (op)
      1: return v | d;
      2: return v & ~d;
      3: return v ^ d;
      default: return d;
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] expv, input string tag, input string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic bus(input logic w, input logic r, input logic [15:0] a,
                     input logic [31:0] d, input string tag);
    int kind, idx, op;
    logic [31:0] old;
    we = w; re = r; addr = a; wdata = d;
    @(posedge clk);
    mdec(a, kind, idx, op);
    old = (kind == 1) ? m_ana[idx] : (kind == 2) ? m_pmu[idx] : (kind == 3) ? ID_V : 32'h0;
    if (r) exp_rdata = old;
    exp_err = ((w || r) && kind == 0) || (w && kind == 3);
    if (w && kind == 1) m_ana[idx] = apply(old, d, op);
    if (w && kind == 2) m_pmu[idx] = apply(old, d, op);
    @(negedge clk);
    check(rdata, exp_rdata, tag, "rdata");
    check({31'b0, err}, {31'b0, exp_err}, tag, "err");
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    bus(1'b0, 1'b1, a, 32'h0, tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input string tag);
    bus(1'b1, 1'b0, a, d, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ANA_W/4; i++) m_ana[i] = ana_init(i);
    for (int i = 0; i < PMU_W/4; i++) m_pmu[i] = 32'h0;
    exp_rdata = '0;
    exp_err   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R6 reset state of the outputs
    check(rdata, 32'h0, "R6", "rdata after reset");
    check({31'b0, err}, 32'h0, "R6", "err after reset");

    // R6 reset contents of both arrays
    for (int i = 0; i < ANA_W/4; i++) rd(16'(ANA_B + 16*i), "R6");
    for (int i = 0; i < PMU_W/4; i++) rd(16'(PMU_B + 16*i), "R6");
    rd(16'(ID_A), "R5");

    // R1 and R3: plain write, read back on every alias
    wr(16'h0090, 32'ha5a5_0001, "R1");
    rd(16'h0090, "R1");
    rd(16'h0094, "R3");
    rd(16'h0098, "R3");
    rd(16'h009c, "R3");
    wr(16'h0220, 32'h1234_5678, "R1");
    rd(16'h022c, "R3");
    idle_step("R3");

    // R2: set, clear, flip aliases
    wr(16'h0094, 32'h0000_00f0, "R2");
    rd(16'h0090, "R2");
    wr(16'h0098, 32'ha000_000f, "R2");
    rd(16'h0090, "R2");
    wr(16'h009c, 32'hffff_0000, "R2");
    rd(16'h0090, "R2");
    wr(16'h0068, 32'h8000_0000, "R2");
    rd(16'h0060, "R2");

    // R4: power window takes over the top of the PLL window
    rd(16'h01f0, "R4");
    wr(16'h0200, 32'hcafe_f00d, "R4");
    rd(16'h01f0, "R4");
    rd(16'h0200, "R4");

    // R5: identification word inside the widened power window
    wr(16'h0804, 32'h0000_0011, "R5");
    wr(16'h0800, 32'hdead_beef, "R5");
    rd(16'h0804, "R5");
    rd(16'h0800, "R5");
    rd(16'h080c, "R5");

    // R7: unmapped addresses
    rd(16'h0000, "R7");
    rd(16'h005c, "R7");
    wr(16'h0a00, 32'hffff_ffff, "R7");
    rd(16'h0a00, "R7");
    rd(16'hfffc, "R7");

    // R8: misaligned accesses
    rd(16'h0062, "R8");
    wr(16'h0091, 32'h0bad_0bad, "R8");
    rd(16'h0090, "R8");

    // R9: read and write together
    bus(1'b1, 1'b1, 16'h0090, 32'h5555_aaaa, "R9");
    rd(16'h0090, "R9");
    bus(1'b1, 1'b1, 16'h0214, 32'h0000_0003, "R9");

    // R10: error pulse lasts one cycle
    rd(16'h0004, "R10");
    idle_step("R10");
    idle_step("R10");

    for (int n = 0; n < 3000; n++) begin
      int sel;
      logic [15:0] a;
      sel = int'($urandom % 8);
      case (sel)
        0, 1, 2: a = 16'(ANA_B + 4*($urandom % ANA_W));
        3, 4:    a = 16'(PMU_B + 4*($urandom % PMU_W));
        5:       a = 16'(ID_A);
        6:       a = 16'($urandom % 'ha00);
        default: a = {14'($urandom), 2'b00};
      endcase
      bus(1'($urandom), 1'($urandom), a, $urandom, "R2 R3");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic idle_step(input string tag);
    bus(1'b0, 1'b0, 16'h0000, 32'h0, tag);
  endtask

endmodule